// File: doc/BRIEF.md
# Piecewise-Linear Gamma Curve Evaluator

This block maps 12-bit colour components through one gamma curve described by 64 straight-line pieces. The pieces are fixed in position and widen with the input code. The lowest sixteen codes have a piece each. Each octave from 16 up to 511 is split into four equal pieces. Everything from 512 to the top code is cut into 128-code pieces. Every piece holds an unsigned slope with eight fractional bits and a 12-bit value at its first code. The pixel path takes three components per beat and applies the same curve to each. The result is the piece's start value plus the scaled distance into the piece, clamped at full scale.

Software fills the coefficients through a single-beat write port that carries an index, a data word and a strobe. A pixel that enters on the same clock edge as a write still uses the old coefficient. Every pixel that enters later uses the new one. The segment is found from the position of the input's highest set bit, so no search over the boundaries is needed. The pipeline is two register stages deep, and a valid flag travels alongside the data.

Top module: `gamma_pwl_eval`

## Requirements
- R1: While reset is held and after it is released, pix_valid_o and pix_data_o are zero. Every coefficient is cleared, so any pixel evaluates to 0 until the table is written.
- R2: The segment of input x is x when x < 16. For 16 <= x < 512 with highest set bit p (4..8), the segment is 16 + 4*(p-4) + bits [p-1:p-2] of x, and its width is 2^(p-2). For x >= 512, the segment is 32 + (x >> 7) and its width is 128. The segment start is x with the bits below the width cleared.
- R3: A coefficient word sets the slope from bits 27:16 and the start value from bits 11:0. Bits 31:28 and 15:12 have no effect on any result.
- R4: The result is start_value + ((slope * (x - segment_start)) >> 8). A pixel at the first code of its segment returns start_value exactly.
- R5: A result above 4095 is clamped to 4095.
- R6: A pixel sampled at clock edge k appears at the outputs after edge k+2, with pix_valid_o set. A beat sampled with pix_valid_i low gives pix_valid_o low two edges later.
- R7: The three channels, packed at pix_data_i[12*c +: 12] for c = 0..2, read one shared table and are evaluated independently. Equal inputs on a beat give equal outputs.
- R8: A pixel sampled on the same edge as a coefficient write uses the previous coefficient. Pixels sampled on later edges use the new coefficient. Pixels already in the pipeline are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_idx | input | 6 | Segment number written |
| cfg_wdata | input | 32 | Coefficient word (slope 27:16, start value 11:0) |
| pix_valid_i | input | 1 | Input beat qualifier |
| pix_data_i | input | 36 | Three 12-bit input components |
| pix_valid_o | output | 1 | Output beat qualifier |
| pix_data_o | output | 36 | Three 12-bit curve results |

## Verification
Every pixel result and its valid flag are due exactly two rising edges after the input is sampled. The bench drives on falling edges and keeps a two-entry history of expected beats. At each falling edge it compares the outputs with the beat driven two falling edges before. The expected value is computed when the beat is driven, from the bench's own coefficient copy as it stands before any write made in that same beat. Doing so fixes the ordering that R8 requires. The full 4096-code range is swept on all channels for two different tables, one of them with valid gaps.

// File: rtl/gamma_pwl_pkg.sv
package gamma_pwl_pkg;

   // Internal precision of the curve fields
   localparam int LUT_FIELD_W = 12;
   // Fractional bits carried by the slope
   localparam int LUT_FRAC_W  = 8;

   typedef struct packed {
      logic [LUT_FIELD_W-1:0] slope;
      logic [LUT_FIELD_W-1:0] ofs;
   } gam_coef_t;

endpackage

// File: rtl/gamma_seg_decode.sv
module gamma_seg_decode #(
   parameter int PIX_W       = 12,
   parameter int FINE_LOG2   = 4,
   parameter int SUB_BITS    = 2,
   parameter int COARSE_LOG2 = 7,
   parameter int SEG_W       = 6
) (
   input  logic [PIX_W-1:0]       pix_i,
   output logic [SEG_W-1:0]       seg_o,
   output logic [COARSE_LOG2-1:0] delta_o
);
   localparam int FINE_SEG     = 1 << FINE_LOG2;
   localparam int NUM_OCT      = COARSE_LOG2 + SUB_BITS - FINE_LOG2;
   localparam int COARSE_START = 1 << (COARSE_LOG2 + SUB_BITS);
   localparam int COARSE_BASE  = FINE_SEG + (NUM_OCT << SUB_BITS)
                                 - (COARSE_START >> COARSE_LOG2);
   localparam int SUB_MASK     = (1 << SUB_BITS) - 1;

   if (FINE_LOG2 < SUB_BITS) begin : g_bad_fine
      $error("gamma_seg_decode: fine region narrower than sub-division");
   end

   int xv;
   int seg_v;
   int sh_v;
   int delta_v;

   always_comb begin
      xv = 0;
      xv[PIX_W-1:0] = pix_i;
      seg_v = xv;
      sh_v  = 0;
      if (xv >= COARSE_START) begin
         sh_v  = COARSE_LOG2;
         seg_v = COARSE_BASE + (xv >> COARSE_LOG2);
      end else begin
         // ascending scan: the highest set bit wins
         for (int p = FINE_LOG2; p < FINE_LOG2 + NUM_OCT; p++) begin
            if (xv[p]) begin
               sh_v  = p - SUB_BITS;
               seg_v = FINE_SEG + ((p - FINE_LOG2) << SUB_BITS)
                       + ((xv >> (p - SUB_BITS)) & SUB_MASK);
            end
         end
      end
      delta_v = xv & ((1 << sh_v) - 1);
      seg_o   = seg_v[SEG_W-1:0];
      delta_o = delta_v[COARSE_LOG2-1:0];
   end

   // R2: decoded piece lies inside the table and the offset inside the piece
   always_comb begin
      assert_seg_range_R2: assert (seg_v >= 0 && seg_v < (1 << SEG_W)
                                   && delta_v <= xv)
         else $error("segment decode out of range");
   end

endmodule

// File: rtl/gamma_coef_bank.sv
module gamma_coef_bank
   import gamma_pwl_pkg::*;
#(
   parameter int SEG_N     = 64,
   parameter int SEG_W     = 6,
   parameter int WORD_W    = 32,
   parameter int SLOPE_LSB = 16,
   parameter int OFS_LSB   = 0,
   parameter int RD_PORTS  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [SEG_W-1:0]  idx_i,
   input  logic [WORD_W-1:0] wdata_i,
   input  logic [SEG_W-1:0]  rd_idx_i  [RD_PORTS],
   output gam_coef_t         rd_coef_o [RD_PORTS]
);
   localparam logic [WORD_W-1:0] FIELD_MASK =
      (WORD_W'((1 << LUT_FIELD_W) - 1) << SLOPE_LSB) |
      (WORD_W'((1 << LUT_FIELD_W) - 1) << OFS_LSB);

   if (SLOPE_LSB + LUT_FIELD_W > WORD_W || OFS_LSB + LUT_FIELD_W > SLOPE_LSB) begin : g_bad_fields
      $error("gamma_coef_bank: coefficient fields do not fit the word");
   end

   gam_coef_t bank_q [SEG_N];

   logic [WORD_W-1:0] unused_bits;
   assign unused_bits = wdata_i & ~FIELD_MASK;

   gam_coef_t wr_coef;
   assign wr_coef.slope = wdata_i[SLOPE_LSB +: LUT_FIELD_W];
   assign wr_coef.ofs   = wdata_i[OFS_LSB +: LUT_FIELD_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < SEG_N; i++) bank_q[i] <= '0;
      end else if (we_i) begin
         bank_q[idx_i] <= wr_coef;
      end
   end

   for (genvar r = 0; r < RD_PORTS; r++) begin : g_rd
      assign rd_coef_o[r] = bank_q[rd_idx_i[r]];
   end

   // R3: a write lands in the addressed entry with both fields taken from the word
   assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(we_i)) |->
         (bank_q[$past(idx_i)].slope == $past(wdata_i[SLOPE_LSB +: LUT_FIELD_W]) &&
          bank_q[$past(idx_i)].ofs   == $past(wdata_i[OFS_LSB +: LUT_FIELD_W])));

endmodule

// File: rtl/gamma_chan_pipe.sv
module gamma_chan_pipe
   import gamma_pwl_pkg::*;
#(
   parameter int PIX_W   = 12,
   parameter int DELTA_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DELTA_W-1:0] delta_i,
   input  gam_coef_t          coef_i,
   output logic [PIX_W-1:0]   pix_o
);
   localparam int PROD_W = LUT_FIELD_W + DELTA_W;

   if (PROD_W - LUT_FRAC_W > PIX_W + 1) begin : g_bad_prod
      $error("gamma_chan_pipe: interpolation term wider than the sum");
   end

   // stage 1: captured coefficient and distance into the piece
   gam_coef_t          coef_q;
   logic [DELTA_W-1:0] delta_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         coef_q  <= '0;
         delta_q <= '0;
      end else begin
         coef_q  <= coef_i;
         delta_q <= delta_i;
      end
   end

   // stage 2: multiply, scale, add, clamp
   logic [PROD_W-1:0] prod;
   logic [PIX_W:0]    sum;
   logic [PIX_W-1:0]  res;

   assign prod = {{DELTA_W{1'b0}}, coef_q.slope} * {{LUT_FIELD_W{1'b0}}, delta_q};
   assign sum  = {1'b0, coef_q.ofs} + (PIX_W+1)'(prod >> LUT_FRAC_W);
   assign res  = sum[PIX_W] ? {PIX_W{1'b1}} : sum[PIX_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) pix_o <= '0;
      else        pix_o <= res;
   end

   // R4: a result never falls below the start value of its piece
   assert_not_below_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (pix_o >= $past(coef_q.ofs)));

   // R4: at the first code of a piece the result is the start value itself
   assert_first_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (delta_q == '0) |=> (pix_o == $past(coef_q.ofs)));

endmodule

// File: rtl/gamma_pwl_eval.sv
module gamma_pwl_eval
   import gamma_pwl_pkg::*;
#(
   parameter int PIX_W       = 12,
   parameter int CHANNELS    = 3,
   parameter int WORD_W      = 32,
   parameter int SLOPE_LSB   = 16,
   parameter int FINE_LOG2   = 4,
   parameter int SUB_BITS    = 2,
   parameter int COARSE_LOG2 = 7,
   localparam int NUM_OCT    = COARSE_LOG2 + SUB_BITS - FINE_LOG2,
   localparam int SEG_N      = (1 << FINE_LOG2) + (NUM_OCT << SUB_BITS)
                               + (((1 << PIX_W) - (1 << (COARSE_LOG2 + SUB_BITS))) >> COARSE_LOG2),
   localparam int SEG_W      = $clog2(SEG_N)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [SEG_W-1:0]          cfg_idx,
   input  logic [WORD_W-1:0]         cfg_wdata,
   input  logic                      pix_valid_i,
   input  logic [CHANNELS*PIX_W-1:0] pix_data_i,
   output logic                      pix_valid_o,
   output logic [CHANNELS*PIX_W-1:0] pix_data_o
);
   if (PIX_W != LUT_FIELD_W) begin : g_bad_width
      $error("gamma_pwl_eval: pixel width must match coefficient field width");
   end
   if (SEG_N != 64) begin : g_bad_segs
      $error("gamma_pwl_eval: segment layout must give 64 pieces");
   end
   if (CHANNELS < 1) begin : g_bad_ch
      $error("gamma_pwl_eval: at least one channel required");
   end

   logic [SEG_W-1:0]       seg_idx [CHANNELS];
   logic [COARSE_LOG2-1:0] seg_dlt [CHANNELS];
   gam_coef_t              seg_cf  [CHANNELS];

   gamma_coef_bank #(
      .SEG_N(SEG_N), .SEG_W(SEG_W), .WORD_W(WORD_W),
      .SLOPE_LSB(SLOPE_LSB), .OFS_LSB(0), .RD_PORTS(CHANNELS)
   ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .we_i(cfg_we), .idx_i(cfg_idx), .wdata_i(cfg_wdata),
      .rd_idx_i(seg_idx), .rd_coef_o(seg_cf)
   );

   for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
      gamma_seg_decode #(
         .PIX_W(PIX_W), .FINE_LOG2(FINE_LOG2), .SUB_BITS(SUB_BITS),
         .COARSE_LOG2(COARSE_LOG2), .SEG_W(SEG_W)
      ) u_dec (
         .pix_i(pix_data_i[c*PIX_W +: PIX_W]),
         .seg_o(seg_idx[c]),
         .delta_o(seg_dlt[c])
      );

      gamma_chan_pipe #(
         .PIX_W(PIX_W), .DELTA_W(COARSE_LOG2)
      ) u_pipe (
         .clk(clk), .rst_n(rst_n),
         .delta_i(seg_dlt[c]),
         .coef_i(seg_cf[c]),
         .pix_o(pix_data_o[c*PIX_W +: PIX_W])
      );
   end

   // valid travels beside the data through both stages
   logic vld_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q       <= 1'b0;
         pix_valid_o <= 1'b0;
      end else begin
         vld_q       <= pix_valid_i;
         pix_valid_o <= vld_q;
      end
   end

   // channel-equality tracking for the shared-table check
   logic same_in, same_out;
   always_comb begin
      same_in  = pix_valid_i;
      same_out = 1'b1;
      for (int c = 1; c < CHANNELS; c++) begin
         if (pix_data_i[c*PIX_W +: PIX_W] != pix_data_i[0 +: PIX_W]) same_in = 1'b0;
         if (pix_data_o[c*PIX_W +: PIX_W] != pix_data_o[0 +: PIX_W]) same_out = 1'b0;
      end
   end

   // R6: valid out is valid in delayed by exactly two edges
   assert_valid_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n, 2)) |-> (pix_valid_o == $past(pix_valid_i, 2)));

   // R7: identical components on a beat leave as identical results
   assert_shared_curve_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rst_n, 2) && $past(same_in, 2)) |-> same_out);

endmodule

// File: tb/gamma_pwl_eval_tb_top.sv
module gamma_pwl_eval_tb_top;
   localparam int PW = 12;
   localparam int CH = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [5:0]    cfg_idx = '0;
   logic [31:0]   cfg_wdata = '0;
   logic          pix_valid_i = 1'b0;
   logic [CH*PW-1:0] pix_data_i = '0;
   logic          pix_valid_o;
   logic [CH*PW-1:0] pix_data_o;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   gamma_pwl_eval dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
      .pix_valid_i(pix_valid_i), .pix_data_i(pix_data_i),
      .pix_valid_o(pix_valid_o), .pix_data_o(pix_data_o)
   );

   // bench model of the curve
   int seg_lo [64];
   int seg_hi [64];
   int m_slope [64];
   int m_ofs [64];

   // two-deep history of expected beats
   logic   h_live [2];
   logic   h_v    [2];
   int     h_exp  [2][CH];
   string  h_tag  [2];

   function automatic int find_seg(int x);
      int s = 0;
      for (int i = 0; i < 64; i++) if (x >= seg_lo[i]) s = i;
      return s;
   endfunction

   function automatic int model(int x);
      int s = find_seg(x);
      int r = m_ofs[s] + ((m_slope[s] * (x - seg_lo[s])) / 256);
      return (r > 4095) ? 4095 : r;
   endfunction

   function automatic int curve_a(int x);
      return 4095 - ((4095 - x) * (4095 - x)) / 4095;
   endfunction

   task automatic check(string tag, int act, int exp, string what);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic v, input int x0, input int x1, input int x2,
                       input logic we, input int idx, input logic [31:0] wd,
                       input string tag);
      int xs [CH];
      @(negedge clk);
      if (h_live[1]) begin
         check(h_tag[1], int'(pix_valid_o), int'(h_v[1]), "valid_o");
         if (h_v[1]) begin
            for (int c = 0; c < CH; c++)
               check(h_tag[1], int'(pix_data_o[c*PW +: PW]), h_exp[1][c], $sformatf("ch%0d", c));
         end
      end
      h_live[1] = h_live[0]; h_v[1] = h_v[0]; h_tag[1] = h_tag[0];
      for (int c = 0; c < CH; c++) h_exp[1][c] = h_exp[0][c];
      xs[0] = x0; xs[1] = x1; xs[2] = x2;
      pix_valid_i = v;
      for (int c = 0; c < CH; c++) pix_data_i[c*PW +: PW] = PW'(xs[c]);
      cfg_we = we; cfg_idx = 6'(idx); cfg_wdata = wd;
      h_live[0] = 1'b1; h_v[0] = v; h_tag[0] = tag;
      for (int c = 0; c < CH; c++) h_exp[0][c] = model(xs[c]);
      // a write in this beat affects only later beats (R8)
      if (we) begin
         m_slope[idx] = int'(wd[27:16]);
         m_ofs[idx]   = int'(wd[11:0]);
      end
   endtask

   task automatic write_coef(int idx, int slope, int ofs, string tag);
      logic [31:0] wd;
      // junk in the unused nibbles on odd entries (R3)
      wd = {((idx % 2) != 0) ? 4'hA : 4'h0, 12'(slope),
            ((idx % 2) != 0) ? 4'h5 : 4'h0, 12'(ofs)};
      step(1'b0, 0, 0, 0, 1'b1, idx, wd, tag);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(1'b0, 0, 0, 0, 1'b0, 0, 32'h0, "R6");
   endtask

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      int lo = 0;
      int k = 0;
      for (int i = 0; i < 16; i++) begin seg_lo[k] = lo; seg_hi[k] = lo; lo++; k++; end
      for (int o = 0; o < 5; o++)
         for (int j = 0; j < 4; j++) begin
            seg_lo[k] = lo; seg_hi[k] = lo + (4 << o) - 1; lo += (4 << o); k++;
         end
      for (int j = 0; j < 28; j++) begin
         seg_lo[k] = lo; seg_hi[k] = lo + 127; lo += 128; k++;
      end
      for (int i = 0; i < 64; i++) begin m_slope[i] = 0; m_ofs[i] = 0; end
      for (int i = 0; i < 2; i++) begin h_live[i] = 1'b0; h_v[i] = 1'b0; h_tag[i] = ""; end

      // R1: outputs stay zero while reset is held, even with traffic
      pix_valid_i = 1'b1;
      pix_data_i  = {12'd4095, 12'd2000, 12'd77};
      repeat (4) begin
         @(negedge clk);
         check("R1", int'(pix_valid_o), 0, "valid_o in reset");
         check("R1", int'(pix_data_o), 0, "data_o in reset");
      end
      @(negedge clk);
      rst_n = 1'b1;
      pix_valid_i = 1'b0;
      check("R1", int'(pix_valid_o), 0, "valid_o after reset");

      // R1: cleared table gives zero for any code
      step(1'b1, 4095, 1000, 5, 1'b0, 0, 32'h0, "R1");
      step(1'b1, 600, 17, 0, 1'b0, 0, 32'h0, "R1");
      idle(2);

      // table A: gamma-like curve
      for (int i = 0; i < 64; i++) begin
         int w = seg_hi[i] - seg_lo[i];
         int fs = curve_a(seg_lo[i]);
         int fe = curve_a(seg_hi[i]);
         int sl = (w == 0) ? 0 : ((fe - fs) * 256) / w;
         write_coef(i, sl, fs, "R3");
      end
      // R2 R4 R7: full sweep, three distinct patterns per beat
      for (int x = 0; x < 4096; x++)
         step(1'b1, x, (x + 1365) % 4096, 4095 - x, 1'b0, 0, 32'h0, "R2_R4_R7");
      // R7: equal components
      for (int x = 0; x < 4096; x += 97) step(1'b1, x, x, x, 1'b0, 0, 32'h0, "R7");
      idle(2);

      // table B: steep upper pieces to force clamping
      for (int i = 0; i < 64; i++) begin
         if (i >= 48) write_coef(i, 4095, 3900 + i, "R5");
         else         write_coef(i, (i * 211 + 300) % 4096, (i * 97) % 4096, "R3");
      end
      // R5 R6: sweep with gaps in valid
      for (int x = 0; x < 4096; x++)
         step(1'b1 ^ ((x % 3) == 0), 4095 - x, x, (x * 7) % 4096, 1'b0, 0, 32'h0, "R5_R6");
      idle(2);

      // R8: write piece 40 while pixels of that piece stream through
      step(1'b1, 1100, 1024, 1151, 1'b0, 0, 32'h0, "R8");
      step(1'b1, 1100, 1024, 1151, 1'b0, 0, 32'h0, "R8");
      step(1'b1, 1100, 1024, 1151, 1'b1, 40, {4'h0, 12'd256, 4'h0, 12'd100}, "R8");
      step(1'b1, 1100, 1024, 1151, 1'b0, 0, 32'h0, "R8");
      step(1'b1, 1100, 1024, 1151, 1'b0, 0, 32'h0, "R8");
      idle(3);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule